// File: doc/BRIEF.md
# Page-Mode Memory Timing Controller

This controller sits between a requester and main RAM. It serves single-word reads, single-word writes and four-word line reads for an instruction cache. Main RAM is organised in 1 KB pages. The controller remembers the page of the most recent RAM access. An access to that same page completes quickly. An access to any other page pays extra wait states, and reads and writes have separate costs.

A 1 KB on-chip scratchpad window is served locally in a single cycle. It never touches the page record. Both storage arrays are plain synchronous word arrays inside the block.

The requester raises `req_i` while `ready_o` is high. Read words come back on `rdata_o`, each qualified by a one-cycle `rvalid_o` pulse. A one-cycle `done_o` pulse closes every access. Latency is counted from the cycle in which the request is accepted: a latency of L means `done_o` (or the first `rvalid_o`) is high L cycles later.

Top module: `page_mem_ctrl`

## Requirements
- R1: After reset `ready_o` is 1, `done_o` and `rvalid_o` are 0, and no page is recorded, so the first RAM access is always a page miss.
- R2: A RAM read whose page (address bits [31:10]) differs from the recorded page has a latency of 5 cycles.
- R3: A RAM read in the recorded page has a latency of 2 cycles.
- R4: A RAM write has a latency of 5 cycles on a page miss and 3 cycles on a page hit, and it never raises `rvalid_o`.
- R5: A read with `burst_i`=1 returns the four words of the line addressed by bits [31:4], in the order word 0, 1, 2, 3. The first word arrives at the read hit or miss latency, each later word arrives 2 cycles after the one before it, and `done_o` comes with the fourth word.
- R6: Addresses 0x1F800000 to 0x1F8003FF address the scratchpad. Reads and writes there have a latency of 1 cycle, leave the page record unchanged, and treat `burst_i` as 0.
- R7: A request made while `ready_o` is 0 is ignored. It writes no storage and changes no page record.
- R8: A read returns the last data written to the same word. A RAM word is selected by address bits [11:2], so pages that agree in bits [11:10] alias. A scratchpad word is selected by bits [9:2]. `burst_i` is ignored on writes.
- R9: `done_o` and `rvalid_o` are single-cycle pulses. `ready_o` is 1 in the cycle of `done_o`, so a new request can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, accepted when ready_o is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | Four-word line read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Controller idle, request can be accepted |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | rdata_o holds a returned word |
| done_o | output | 1 | Access complete |

## Verification
A stale or corrupted page record does not show up as wrong data. It shows up as a latency error on the very next RAM access: a hit that costs 5 cycles or a miss that finishes in 2 or 3. The bench therefore measures the arrival cycle of every `done_o` and `rvalid_o` and compares it with its own page model. A wrong word counter in a line read shows up within two cycles as a misordered word or a wrong beat spacing. A request that leaks through while the controller is busy shows up later, as altered data or a changed hit/miss outcome when that word or page is accessed again.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } pmc_state_e;

  localparam int PAGE_W = 22;
endpackage

// File: rtl/pmc_page_tracker.sv
module pmc_page_tracker #(
  parameter int PW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [PW-1:0] page_i,
  output logic          hit_o
);
  logic          valid_q;
  logic [PW-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (upd_i) begin
      valid_q <= 1'b1;
      page_q  <= page_i;
    end
  end

  assign hit_o = valid_q && (page_q == page_i);

  // R1
  page_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> valid_q);
endmodule

// File: rtl/pmc_wait_timer.sv
module pmc_wait_timer #(
  parameter int CW      = 3,
  parameter int CNT_MAX = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CNT_MAX));
endmodule

// File: rtl/pmc_word_store.sv
module pmc_word_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/page_mem_ctrl.sv
module page_mem_ctrl #(
  parameter int          RAM_WORDS  = 1024,
  parameter int          SPAD_WORDS = 256,
  parameter int          RD_MISS    = 5,
  parameter int          RD_HIT     = 2,
  parameter int          WR_MISS    = 5,
  parameter int          WR_HIT     = 3,
  parameter logic [21:0] SPAD_PAGE  = 22'h07E000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        burst_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        done_o
);
  import pmc_pkg::*;

  localparam int RAM_AW   = $clog2(RAM_WORDS);
  localparam int SP_AW    = $clog2(SPAD_WORDS);
  localparam int LINE_W   = RAM_AW - 2;
  localparam int MAX_A    = (RD_MISS > WR_MISS) ? RD_MISS : WR_MISS;
  localparam int MAX_COST = (MAX_A > WR_HIT) ? MAX_A : WR_HIT;
  localparam int CNT_MAX  = MAX_COST - 2;
  localparam int CW       = $clog2(MAX_COST) + 1;

  pmc_state_e        st_q;
  logic [LINE_W-1:0] line_q;
  logic [1:0]        word_q;
  logic              we_q, burst_q;
  logic [31:0]       wdata_q, rdata_q;
  logic              rvalid_q, done_q;

  logic              accept, spad_sel, ram_acc, sp_acc, fire, more_beats;
  logic              page_hit, t_zero, t_load;
  logic [CW-1:0]     first_load, t_val;
  logic [31:0]       ram_rdata, sp_rdata;

  assign accept   = req_i && (st_q == ST_IDLE);
  assign spad_sel = (addr_i[31:10] == SPAD_PAGE);
  assign ram_acc  = accept && !spad_sel;
  assign sp_acc   = accept && spad_sel;
  assign fire     = (st_q == ST_WAIT) && t_zero;
  assign more_beats = !we_q && burst_q && (word_q != 2'd3);

  always_comb begin
    if (we_i) first_load = page_hit ? CW'(WR_HIT - 2) : CW'(WR_MISS - 2);
    else      first_load = page_hit ? CW'(RD_HIT - 2) : CW'(RD_MISS - 2);
  end

  // later line words are always page hits
  assign t_load = ram_acc || (fire && more_beats);
  assign t_val  = ram_acc ? first_load : CW'(RD_HIT - 1);

  pmc_page_tracker #(.PW(PAGE_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (ram_acc),
    .page_i (addr_i[31:10]),
    .hit_o  (page_hit)
  );

  pmc_wait_timer #(.CW(CW), .CNT_MAX(CNT_MAX)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  pmc_word_store #(.DEPTH(RAM_WORDS), .AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (fire && we_q),
    .waddr_i ({line_q, word_q}),
    .wdata_i (wdata_q),
    .raddr_i ({line_q, word_q}),
    .rdata_o (ram_rdata)
  );

  pmc_word_store #(.DEPTH(SPAD_WORDS), .AW(SP_AW)) u_spad (
    .clk_i   (clk_i),
    .we_i    (sp_acc && we_i),
    .waddr_i (addr_i[SP_AW+1:2]),
    .wdata_i (wdata_i),
    .raddr_i (addr_i[SP_AW+1:2]),
    .rdata_o (sp_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      line_q   <= '0;
      word_q   <= '0;
      we_q     <= 1'b0;
      burst_q  <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      if (sp_acc) begin
        done_q <= 1'b1;
        if (!we_i) begin
          rvalid_q <= 1'b1;
          rdata_q  <= sp_rdata;
        end
      end else if (ram_acc) begin
        st_q    <= ST_WAIT;
        line_q  <= addr_i[RAM_AW+1:4];
        word_q  <= (burst_i && !we_i) ? 2'd0 : addr_i[3:2];
        we_q    <= we_i;
        burst_q <= burst_i && !we_i;
        wdata_q <= wdata_i;
      end else if (fire) begin
        if (we_q) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end else begin
          rdata_q  <= ram_rdata;
          rvalid_q <= 1'b1;
          if (more_beats) begin
            word_q <= word_q + 2'd1;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
      end
    end
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = done_q;

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  // R6
  spad_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_acc |=> done_o);

  // R4
  wr_no_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && we_q) |=> (done_o && !rvalid_o));

  // R5
  burst_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !done_o) |-> !ready_o);
endmodule

// File: tb/tb_page_mem_ctrl.sv
`timescale 1ns/1ps
module tb_page_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, burst_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        ready_o, rvalid_o, done_o;
  logic [31:0] rdata_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] ref_ram [1024];
  bit          ram_kn  [1024];
  logic [31:0] ref_sp  [256];
  bit          sp_kn   [256];
  bit          ref_pv = 1'b0;
  logic [21:0] ref_pg = '0;

  page_mem_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .burst_i(burst_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_spad(input logic [31:0] a);
    return a[31:10] == 22'h07E000;
  endfunction

  function automatic int exp_lat(input bit we, input bit hit);
    if (we) return hit ? 3 : 5;
    return hit ? 2 : 5;
  endfunction

  // inject: drive a write while the controller is busy (must be ignored)
  task automatic access(input bit we, input bit bst, input logic [31:0] a,
                        input logic [31:0] d, input bit inject, input logic [31:0] inj_a);
    bit sp = is_spad(a);
    bit eb = bst && !we && !sp;
    bit hit = ref_pv && (ref_pg == a[31:10]);
    int lat = sp ? 1 : exp_lat(we, hit);
    int nb = we ? 0 : (eb ? 4 : 1);
    int k = 0, b = 0;
    bit fin = 1'b0;
    string tag;
    if (sp) tag = "R6";
    else if (!ref_pv) tag = "R1";
    else if (eb) tag = "R5";
    else if (we) tag = "R4";
    else tag = hit ? "R3" : "R2";
    if (!sp) begin ref_pv = 1'b1; ref_pg = a[31:10]; end
    req_i = 1'b1; we_i = we; burst_i = bst; addr_i = a; wdata_i = d;
    while (!fin && k < 40) begin
      @(posedge clk); @(negedge clk); k++;
      req_i = 1'b0;
      if (rvalid_o) begin
        logic [31:0] ev;
        bit kn;
        chk(!we, "R4", 32'(we), 0);
        chk(k == lat + 2*b, tag, k, lat + 2*b);
        if (sp) begin ev = ref_sp[a[9:2]]; kn = sp_kn[a[9:2]]; end
        else begin
          logic [9:0] ix = eb ? {a[11:4], 2'(b)} : a[11:2];
          ev = ref_ram[ix]; kn = ram_kn[ix];
        end
        if (kn) chk(rdata_o == ev, "R8", rdata_o, ev);
        b++;
      end
      if (done_o) begin
        fin = 1'b1;
        chk(k == lat + (eb ? 6 : 0), tag, k, lat + (eb ? 6 : 0));
        chk(ready_o, "R9", ready_o, 1);
        chk(b == nb, "R5", b, nb);
      end else if (inject && k == 1) begin
        chk(!ready_o, "R7", ready_o, 0);
        req_i = 1'b1; we_i = 1'b1; burst_i = 1'b0; addr_i = inj_a; wdata_i = 32'hDEAD_BEEF;
      end
    end
    req_i = 1'b0;
    if (!fin) chk(1'b0, tag, 0, 1);
    if (we) begin
      if (sp) begin ref_sp[a[9:2]] = d; sp_kn[a[9:2]] = 1'b1; end
      else begin ref_ram[a[11:2]] = d; ram_kn[a[11:2]] = 1'b1; end
    end
  endtask

  function automatic logic [31:0] pick_addr();
    logic [21:0] pg;
    case ($urandom % 7)
      0: pg = 22'h07E000;
      1: pg = 22'h000000;
      2: pg = 22'h000001;
      3: pg = 22'h000002;
      4: pg = 22'h000200;
      5: pg = 22'h020003;
      default: pg = 22'h000005;
    endcase
    return {pg, 4'd0, 4'($urandom % 16), 2'b00};
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1, "R1", ready_o, 1);
    chk(done_o == 1'b0 && rvalid_o == 1'b0, "R1", {done_o, rvalid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    access(1, 0, 32'h0000_0400, 32'h1111_0001, 0, 0);      // first: miss (R1)
    access(1, 1, 32'h0000_0404, 32'h1111_0002, 0, 0);      // R4 hit, R8 burst ignored on write
    access(1, 0, 32'h0000_0408, 32'h1111_0003, 0, 0);
    access(1, 0, 32'h0000_040C, 32'h1111_0004, 0, 0);
    access(0, 0, 32'h0000_0404, 0, 0, 0);                   // R3
    access(1, 0, 32'h0000_0C20, 32'h3333_0020, 0, 0);       // R4 miss
    access(0, 0, 32'h0000_0810, 0, 0, 0);                   // R2
    access(1, 0, 32'h1F80_03FC, 32'h5A5A_A5A5, 0, 0);       // R6 top of window
    access(0, 1, 32'h1F80_03FC, 0, 0, 0);                   // R6 burst ignored
    access(0, 0, 32'h0000_0814, 0, 0, 0);                   // R6 page kept -> hit
    access(0, 1, 32'h0000_0408, 0, 0, 0);                   // R5 miss line
    access(0, 1, 32'h0000_0400, 0, 0, 0);                   // R5 hit line
    access(0, 0, 32'h1F80_0400, 0, 0, 0);                   // just outside window: RAM miss
    // R7: busy-time write to page 3 must not land or move the page
    access(0, 0, 32'h0000_0404, 0, 1, 32'h0000_0C20);
    access(0, 0, 32'h0000_040C, 0, 0, 0);                   // R7 still hit
    access(0, 0, 32'h0000_0C20, 0, 0, 0);                   // R7 data unchanged
    access(0, 0, 32'h0008_0404, 0, 0, 0);                   // R8 alias of 0x404

    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 10;
      logic [31:0] a = pick_addr();
      access(r < 4, (r % 3) == 0, a, $urandom, 0, 0);
    end

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule